// File: doc/BRIEF.md
# Indirect-Access Interrupt Router Register File

This block holds the programmable state of an I/O interrupt router and gives software a way to reach it. A 32-bit slave port exposes only two word locations: a select register at byte offset 0 and a data window at byte offset 16. Software first writes a register index into the select register, then reads or writes the data window to touch that register. The reachable registers are an identification byte, a read-only version word, an arbitration identification byte, and a table of redirection entries, each entry split into a low and a high 32-bit half.

Every entry's fields (vector, delivery mode, destination mode, polarity, trigger mode, mask and destination byte) are presented in parallel on flat output buses, so the delivery logic next to this block can read all entries at once without going through the port. Each port access receives a response one cycle later that carries read data and an error flag.

Top module: `irq_router_regs`

## Requirements
- R1: Byte offset 0 is the select register; a legal write keeps wdata[7:0], a read returns it zero-extended to 32 bits, and it resets to 0.
- R2: Every access (acc_valid high for one cycle) produces rsp_valid high exactly in the following cycle; a legal read at offset 16 returns the register named by the select register, and a write returns rsp_rdata of 0.
- R3: An access whose acc_size is not 4 or whose acc_addr is neither 0 nor 16 returns rsp_err=1 with rsp_rdata=0 and changes no state.
- R4: Index 0 is the ID register; a write keeps wdata[31:24], a read returns the ID in bits 31:24 with all other bits zero, and it resets to the ID_RESET parameter.
- R5: Index 1 is the version register; it reads ((NUM_ENT-1) << 16) | 0x11 (0x00170011 with 24 entries) and writes to it change nothing.
- R6: Index 2 is the arbitration ID; it keeps only wdata[31:24], reads back in bits 31:24, and resets to ID_RESET.
- R7: Entry n is reached at index 0x10+2n (low half) and 0x10+2n+1 (high half); a write to one entry or half leaves every other entry and half unchanged.
- R8: A write to a low half keeps only bits under mask 0x0001AFFF and a write to a high half keeps only bits 31:24; the other bits read back as zero regardless of the written value.
- R9: After reset every entry's mask bit is 1 and all its other fields are 0, so the low half reads 0x00010000 and the high half reads 0.
- R10: Indices 3 to 0x0F and indices from 0x10+2*NUM_ENT upward read as zero, and writes to them change no state.
- R11: Each entry's fields appear on the parallel outputs: vector = low[7:0], delivery mode = low[10:8], destination mode = low[11], polarity = low[13], trigger mode = low[15], mask = low[16], destination = high[31:24]; entry n occupies slice n of each bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset within the port |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_err | output | 1 | Illegal size or offset |
| rsp_rdata | output | 32 | Read data |
| id_val | output | 8 | Current ID byte |
| arb_val | output | 8 | Current arbitration ID byte |
| ent_vector | output | 8*NUM_ENT | Vector of each entry |
| ent_dmode | output | 3*NUM_ENT | Delivery mode of each entry |
| ent_dstmode | output | NUM_ENT | Destination mode of each entry |
| ent_polarity | output | NUM_ENT | Polarity of each entry |
| ent_trigger | output | NUM_ENT | Trigger mode of each entry |
| ent_mask | output | NUM_ENT | Mask bit of each entry |
| ent_dest | output | 8*NUM_ENT | Destination byte of each entry |

## Verification
The assertions watch, on every cycle, that each access is answered exactly one cycle later, that illegal accesses and writes to the version or undefined indices leave the ID, arbitration and mask state untouched, and that all masks are set right after reset. What they cannot see is whether a value landed in the right entry and half, whether reserved bits were stripped, and whether readback and the parallel field buses agree with what was written; the bench's reference model covers those through directed writes to the first and last entries, all-ones patterns, out-of-range indices and bad sizes, comparing the parallel outputs against its own table on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Port byte offsets and the only legal access size
    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;
    localparam logic [2:0] WORD_BYTES = 3'd4;

    // Register indices reached through the window
    localparam logic [7:0] IX_ID   = 8'h00;
    localparam logic [7:0] IX_VER  = 8'h01;
    localparam logic [7:0] IX_ARB  = 8'h02;
    localparam int         TBL_BASE = 16;
    localparam logic [7:0] VER_CODE = 8'h11;

    typedef enum logic [2:0] {
        RK_ID,
        RK_VER,
        RK_ARB,
        RK_ENT,
        RK_NONE
    } reg_kind_e;

    // Low half of a table entry: only the defined fields are stored
    typedef struct packed {
        logic       mask;
        logic       trig;
        logic       pol;
        logic       dstm;
        logic [2:0] dmode;
        logic [7:0] vec;
    } ent_lo_t;

    localparam ent_lo_t LO_RESET = '{mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                     dstm: 1'b0, dmode: 3'd0, vec: 8'd0};

    function automatic logic [31:0] lo_to_word(ent_lo_t e);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = e.vec;
        w[10:8]  = e.dmode;
        w[11]    = e.dstm;
        w[13]    = e.pol;
        w[15]    = e.trig;
        w[16]    = e.mask;
        return w;
    endfunction

    function automatic ent_lo_t word_to_lo(logic [31:0] w);
        ent_lo_t e;
        e.vec   = w[7:0];
        e.dmode = w[10:8];
        e.dstm  = w[11];
        e.pol   = w[13];
        e.trig  = w[15];
        e.mask  = w[16];
        return e;
    endfunction

    function automatic logic [31:0] version_word(int n_ent);
        logic [7:0] top_ix;
        top_ix = 8'(n_ent - 1);
        return {8'h00, top_ix, 8'h00, VER_CODE};
    endfunction

endpackage

// File: rtl/irq_rt_decode.sv
module irq_rt_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_ENT = 24,
    localparam int IDXW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic [7:0]      sel,
    output reg_kind_e       kind,
    output logic [IDXW-1:0] ent_idx,
    output logic            hi_half
);
    localparam int TBL_END = TBL_BASE + 2 * NUM_ENT;

    logic [7:0] rel;

    always_comb begin
        kind    = RK_NONE;
        ent_idx = '0;
        hi_half = 1'b0;
        rel     = sel - 8'(TBL_BASE);
        if (sel == IX_ID) begin
            kind = RK_ID;
        end else if (sel == IX_VER) begin
            kind = RK_VER;
        end else if (sel == IX_ARB) begin
            kind = RK_ARB;
        end else if (int'(sel) >= TBL_BASE && int'(sel) < TBL_END) begin
            kind    = RK_ENT;
            ent_idx = rel[IDXW:1];
            hi_half = rel[0];
        end
    end
endmodule

// File: rtl/irq_rt_entry.sv
module irq_rt_entry
    import irq_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output ent_lo_t     lo_q,
    output logic [7:0]  dest_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= LO_RESET;
            dest_q <= '0;
        end else begin
            if (wr_lo) lo_q   <= word_to_lo(wdata);
            if (wr_hi) dest_q <= wdata[31:24];
        end
    end
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int         NUM_ENT  = 24,
    parameter logic [7:0] ID_RESET = 8'h05
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [7:0]           acc_addr,
    input  logic [2:0]           acc_size,
    input  logic [31:0]          acc_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [31:0]          rsp_rdata,
    output logic [7:0]           id_val,
    output logic [7:0]           arb_val,
    output logic [8*NUM_ENT-1:0] ent_vector,
    output logic [3*NUM_ENT-1:0] ent_dmode,
    output logic [NUM_ENT-1:0]   ent_dstmode,
    output logic [NUM_ENT-1:0]   ent_polarity,
    output logic [NUM_ENT-1:0]   ent_trigger,
    output logic [NUM_ENT-1:0]   ent_mask,
    output logic [8*NUM_ENT-1:0] ent_dest
);
    localparam int IDXW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    logic [7:0]      sel_q;
    logic [7:0]      id_q;
    logic [7:0]      arb_q;
    reg_kind_e       kind;
    logic [IDXW-1:0] ent_idx;
    logic            hi_half;
    ent_lo_t         lo_arr   [NUM_ENT];
    logic [7:0]      dest_arr [NUM_ENT];

    logic legal, hit_sel, hit_win, sel_wr, win_wr;
    logic [31:0] rd_word;

    assign legal   = (acc_size == WORD_BYTES) &&
                     (acc_addr == OFF_SELECT || acc_addr == OFF_WINDOW);
    assign hit_sel = acc_valid && legal && (acc_addr == OFF_SELECT);
    assign hit_win = acc_valid && legal && (acc_addr == OFF_WINDOW);
    assign sel_wr  = hit_sel && acc_write;
    assign win_wr  = hit_win && acc_write;

    irq_rt_decode #(.NUM_ENT(NUM_ENT)) u_dec (
        .sel     (sel_q),
        .kind    (kind),
        .ent_idx (ent_idx),
        .hi_half (hi_half)
    );

    generate
        for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
            logic hit_ent;
            assign hit_ent = win_wr && (kind == RK_ENT) && (ent_idx == IDXW'(g));

            irq_rt_entry u_ent (
                .clk    (clk),
                .rst    (rst),
                .wr_lo  (hit_ent && !hi_half),
                .wr_hi  (hit_ent && hi_half),
                .wdata  (acc_wdata),
                .lo_q   (lo_arr[g]),
                .dest_q (dest_arr[g])
            );

            assign ent_vector[g*8 +: 8]  = lo_arr[g].vec;
            assign ent_dmode[g*3 +: 3]   = lo_arr[g].dmode;
            assign ent_dstmode[g]        = lo_arr[g].dstm;
            assign ent_polarity[g]       = lo_arr[g].pol;
            assign ent_trigger[g]        = lo_arr[g].trig;
            assign ent_mask[g]           = lo_arr[g].mask;
            assign ent_dest[g*8 +: 8]    = dest_arr[g];
        end
    endgenerate

    // Readback of the selected register
    always_comb begin
        rd_word = '0;
        unique case (kind)
            RK_ID:   rd_word = {id_q, 24'h0};
            RK_VER:  rd_word = version_word(NUM_ENT);
            RK_ARB:  rd_word = {arb_q, 24'h0};
            RK_ENT:  rd_word = hi_half ? {dest_arr[ent_idx], 24'h0}
                                       : lo_to_word(lo_arr[ent_idx]);
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= ID_RESET;
            arb_q <= ID_RESET;
        end else begin
            if (sel_wr) sel_q <= acc_wdata[7:0];
            if (win_wr && kind == RK_ID)  id_q  <= acc_wdata[31:24];
            if (win_wr && kind == RK_ARB) arb_q <= acc_wdata[31:24];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid && !legal;
            if (acc_valid && legal && !acc_write)
                rsp_rdata <= hit_sel ? {24'h0, sel_q} : rd_word;
            else
                rsp_rdata <= '0;
        end
    end

    assign id_val  = id_q;
    assign arb_val = arb_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_ENT = 24
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [7:0]         acc_addr,
    input logic [2:0]         acc_size,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [31:0]        rsp_rdata,
    input logic [7:0]         id_val,
    input logic [7:0]         arb_val,
    input logic [NUM_ENT-1:0] ent_mask,
    input logic [7:0]         sel_q
);
    localparam int TBL_END = 16 + 2 * NUM_ENT;

    logic bad_acc, win_write, undef_sel;
    assign bad_acc   = acc_valid && (acc_size != 3'd4 ||
                       (acc_addr != 8'h00 && acc_addr != 8'h10));
    assign win_write = acc_valid && acc_write && acc_size == 3'd4 && acc_addr == 8'h10;
    assign undef_sel = (int'(sel_q) > 2 && int'(sel_q) < 16) || int'(sel_q) >= TBL_END;

    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);

    a_r3_bad_acc_inert: assert property (@(posedge clk) disable iff (rst)
        bad_acc |=> rsp_err && rsp_rdata == 32'h0 && $stable(id_val) &&
                    $stable(arb_val) && $stable(ent_mask) && $stable(sel_q));

    a_r5_version_ro: assert property (@(posedge clk) disable iff (rst)
        (win_write && sel_q == 8'h01) |=> $stable(id_val) && $stable(arb_val) &&
                                          $stable(ent_mask));

    a_r10_undef_write_inert: assert property (@(posedge clk) disable iff (rst)
        (win_write && undef_sel) |=> $stable(id_val) && $stable(arb_val) &&
                                     $stable(ent_mask));

    a_r4_id_needs_write: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> $stable(id_val) && $stable(arb_val) &&
                                      $stable(ent_mask));

    a_r9_masked_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&ent_mask));
endmodule

bind irq_router_regs irq_router_chk #(.NUM_ENT(NUM_ENT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .id_val    (id_val),
    .arb_val   (arb_val),
    .ent_mask  (ent_mask),
    .sel_q     (sel_q)
);

// File: tb/irq_router_regs_test.sv
`timescale 1ns/1ps
module irq_router_regs_test;
    localparam int         N   = 24;
    localparam logic [7:0] IDR = 8'h05;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [7:0]  id_val, arb_val;
    logic [8*N-1:0] ent_vector, ent_dest;
    logic [3*N-1:0] ent_dmode;
    logic [N-1:0]   ent_dstmode, ent_polarity, ent_trigger, ent_mask;

    always #2.5 clk = ~clk;

    irq_router_regs #(.NUM_ENT(N), .ID_RESET(IDR)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .id_val(id_val), .arb_val(arb_val), .ent_vector(ent_vector),
        .ent_dmode(ent_dmode), .ent_dstmode(ent_dstmode),
        .ent_polarity(ent_polarity), .ent_trigger(ent_trigger),
        .ent_mask(ent_mask), .ent_dest(ent_dest)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [7:0]  sel_m, id_m, arb_m;
    logic [31:0] lo_m [N];
    logic [31:0] hi_m [N];

    function automatic logic [31:0] ref_read(logic [7:0] s);
        int k;
        k = int'(s);
        if (k == 0) return {id_m, 24'h0};
        if (k == 1) return ((N - 1) << 16) | 32'h11;
        if (k == 2) return {arb_m, 24'h0};
        if (k >= 16 && k < 16 + 2 * N) begin
            if (k % 2 == 1) return hi_m[(k - 16) / 2];
            return lo_m[(k - 16) / 2];
        end
        return 32'h0;
    endfunction

    task automatic ref_write(logic [7:0] s, logic [31:0] d);
        int k;
        k = int'(s);
        if (k == 0) id_m = d[31:24];
        else if (k == 2) arb_m = d[31:24];
        else if (k >= 16 && k < 16 + 2 * N) begin
            if (k % 2 == 1) hi_m[(k - 16) / 2] = d & 32'hFF00_0000;
            else            lo_m[(k - 16) / 2] = d & 32'h0001_AFFF;
        end
    endtask

    task automatic ref_reset();
        sel_m = 8'h00;
        id_m  = IDR;
        arb_m = IDR;
        for (int i = 0; i < N; i++) begin
            lo_m[i] = 32'h0001_0000;
            hi_m[i] = 32'h0;
        end
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of the parallel outputs (R11) and ID bytes (R4, R6)
    always @(negedge clk) begin
        if (mon_on) begin
            bit ok;
            ok = (id_val == id_m) && (arb_val == arb_m);
            for (int i = 0; i < N; i++) begin
                if (ent_vector[i*8 +: 8] != lo_m[i][7:0])   ok = 1'b0;
                if (ent_dmode[i*3 +: 3]  != lo_m[i][10:8])  ok = 1'b0;
                if (ent_dstmode[i]       != lo_m[i][11])    ok = 1'b0;
                if (ent_polarity[i]      != lo_m[i][13])    ok = 1'b0;
                if (ent_trigger[i]       != lo_m[i][15])    ok = 1'b0;
                if (ent_mask[i]          != lo_m[i][16])    ok = 1'b0;
                if (ent_dest[i*8 +: 8]   != hi_m[i][31:24]) ok = 1'b0;
            end
            check(ok, "R11 parallel fields", {16'h0, id_val, arb_val}, {16'h0, id_m, arb_m});
        end
    end

    // One access; called right after a negedge. Returns the response data.
    task automatic access(bit wr, logic [7:0] a, logic [2:0] sz, logic [31:0] wd,
                          output logic [31:0] rd);
        bit bad;
        logic [31:0] exp_rd;
        bad    = (sz != 3'd4) || (a != 8'h00 && a != 8'h10);
        exp_rd = (bad || wr) ? 32'h0 : (a == 8'h00 ? {24'h0, sel_m} : ref_read(sel_m));
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = wd;
        @(posedge clk);
        #1;
        if (!bad && wr) begin
            if (a == 8'h00) sel_m = wd[7:0];
            else            ref_write(sel_m, wd);
        end
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check(rsp_valid == 1'b1, "R2 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check(rsp_err == bad, "R3 rsp_err", {31'h0, rsp_err}, {31'h0, bad});
        check(rsp_rdata == exp_rd, "R2 rsp_rdata", rsp_rdata, exp_rd);
        rd = rsp_rdata;
    endtask

    task automatic set_sel(logic [7:0] s);
        logic [31:0] r;
        access(1'b1, 8'h00, 3'd4, {24'h0, s}, r);
    endtask

    task automatic rd_reg(logic [7:0] s, output logic [31:0] r);
        set_sel(s);
        access(1'b0, 8'h10, 3'd4, 32'h0, r);
    endtask

    task automatic wr_reg(logic [7:0] s, logic [31:0] d);
        logic [31:0] r;
        set_sel(s);
        access(1'b1, 8'h10, 3'd4, d, r);
    endtask

    initial begin
        logic [31:0] r;
        ref_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        check(rsp_valid == 1'b0, "R2 idle after reset", {31'h0, rsp_valid}, 32'h0);

        // Reset values
        access(1'b0, 8'h00, 3'd4, 32'h0, r);
        check(r == 32'h0, "R1 select reset", r, 32'h0);
        rd_reg(8'h00, r);
        check(r == {IDR, 24'h0}, "R4 ID reset", r, {IDR, 24'h0});
        rd_reg(8'h01, r);
        check(r == 32'h0017_0011, "R5 version word", r, 32'h0017_0011);
        rd_reg(8'h02, r);
        check(r == {IDR, 24'h0}, "R6 arb reset", r, {IDR, 24'h0});
        rd_reg(8'h10, r);
        check(r == 32'h0001_0000, "R9 entry0 low reset", r, 32'h0001_0000);
        rd_reg(8'h3F, r);
        check(r == 32'h0, "R9 entry23 high reset", r, 32'h0);

        // Select register keeps the low byte
        access(1'b1, 8'h00, 3'd4, 32'hDEAD_02A5, r);
        access(1'b0, 8'h00, 3'd4, 32'h0, r);
        check(r == 32'h0000_00A5, "R1 select readback", r, 32'h0000_00A5);

        // ID and arbitration ID
        wr_reg(8'h00, 32'hFFFF_FFFF);
        rd_reg(8'h00, r);
        check(r == 32'hFF00_0000, "R4 ID write", r, 32'hFF00_0000);
        wr_reg(8'h02, 32'h1234_5678);
        rd_reg(8'h02, r);
        check(r == 32'h1200_0000, "R6 arb write", r, 32'h1200_0000);

        // Version ignores writes
        wr_reg(8'h01, 32'hFFFF_FFFF);
        rd_reg(8'h01, r);
        check(r == 32'h0017_0011, "R5 version after write", r, 32'h0017_0011);

        // Reserved bits cleared
        wr_reg(8'h1A, 32'hFFFF_FFFF);
        rd_reg(8'h1A, r);
        check(r == 32'h0001_AFFF, "R8 low half reserved", r, 32'h0001_AFFF);
        wr_reg(8'h1B, 32'hFFFF_FFFF);
        rd_reg(8'h1B, r);
        check(r == 32'hFF00_0000, "R8 high half reserved", r, 32'hFF00_0000);

        // Last entry, neighbours untouched
        wr_reg(8'h3E, 32'h0000_A0C5);
        wr_reg(8'h3F, 32'h7700_0000);
        rd_reg(8'h3E, r);
        check(r == 32'h0000_A0C5, "R7 entry23 low", r, 32'h0000_A0C5);
        rd_reg(8'h3F, r);
        check(r == 32'h7700_0000, "R7 entry23 high", r, 32'h7700_0000);
        rd_reg(8'h3C, r);
        check(r == 32'h0001_0000, "R7 entry22 untouched", r, 32'h0001_0000);
        wr_reg(8'h10, 32'h0000_0931);
        rd_reg(8'h11, r);
        check(r == 32'h0, "R7 entry0 high untouched", r, 32'h0);

        // Undefined indices
        wr_reg(8'h03, 32'hFFFF_FFFF);
        rd_reg(8'h03, r);
        check(r == 32'h0, "R10 index 3", r, 32'h0);
        wr_reg(8'h0F, 32'hFFFF_FFFF);
        rd_reg(8'h0F, r);
        check(r == 32'h0, "R10 index 0x0F", r, 32'h0);
        wr_reg(8'h40, 32'hFFFF_FFFF);
        rd_reg(8'h40, r);
        check(r == 32'h0, "R10 index 0x40", r, 32'h0);
        rd_reg(8'hFF, r);
        check(r == 32'h0, "R10 index 0xFF", r, 32'h0);

        // Illegal accesses
        set_sel(8'h12);
        access(1'b1, 8'h10, 3'd2, 32'h0000_00FF, r);
        check(r == 32'h0, "R3 short write data", r, 32'h0);
        access(1'b1, 8'h04, 3'd4, 32'h0000_0000, r);
        access(1'b0, 8'h14, 3'd4, 32'h0, r);
        check(r == 32'h0, "R3 bad offset read", r, 32'h0);
        access(1'b0, 8'h00, 3'd4, 32'h0, r);
        check(r == 32'h0000_0012, "R3 select kept", r, 32'h0000_0012);
        access(1'b0, 8'h10, 3'd4, 32'h0, r);
        check(r == 32'h0001_0000, "R3 entry1 kept", r, 32'h0001_0000);

        // Back-to-back accesses
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 8'h00; acc_size = 3'd4;
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2 back-to-back first", {31'h0, rsp_valid}, 32'h1);
        @(negedge clk);
        acc_valid = 1'b0;
        check(rsp_valid == 1'b1, "R2 back-to-back second", {31'h0, rsp_valid}, 32'h1);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 response ends", {31'h0, rsp_valid}, 32'h0);

        // Reset restores entries
        rst = 1'b1;
        mon_on = 1'b0;
        @(posedge clk);
        #1 ref_reset();
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        rd_reg(8'h1A, r);
        check(r == 32'h0001_0000, "R9 entry5 after reset", r, 32'h0001_0000);

        repeat (2) @(negedge clk);
        done = 1'b1;
        mon_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule